// File: doc/BRIEF.md
# I2C Byte-Command Master

This block is an I2C bus master that a host programs through a small 8-bit register port. The host sets a 16-bit clock divider, enables the core, loads a byte and writes one command word. Each command moves at most one byte. It can open the transfer with a START condition, shift a byte out or in, place the acknowledge bit after a read, and close with a STOP condition. Several of these actions can be requested together in one command write.

SCL and SDA are open-drain. The block only ever pulls a line low: an output enable at 1 means "drive low". The block watches both lines through its own synchronized inputs. These inputs are used to sample data and acknowledges, to track whether the bus is busy, and to detect when another master wins arbitration.

Completion is reported through a status location, which shares its address with the command location. An interrupt flag can also be routed to an interrupt output. Sequencing of multi-byte messages is left to the host, which issues one command per byte.

Top module: `i2c_byte_master`

## Requirements
- R1: Register map on `host_addr`. Offset 0 is the divider low byte and offset 1 the divider high byte; both reset to 0xFF. Offset 2 is control: bit 7 enables the core, bit 6 enables the interrupt, and it resets to 0. Offset 3 is the transmit byte on write and the received byte on read. Offset 4 is the command on write and the status on read; status resets to 0. A read returns data one clock after the address is presented.
- R2: With divider value P, each bit on SCL lasts 5*(P+1) clock cycles, so consecutive SCL rising edges within a transfer are exactly 5*(P+1) cycles apart.
- R3: Command bit 7 (START) generates a start condition and then transmits the byte in the transmit register, MSB first. Status bit 6 (bus busy) sets when a start condition (SDA falling while SCL is high) is seen on the synchronized lines.
- R4: Command bit 4 (WRITE) shifts out the transmit byte MSB first and samples the slave's acknowledge bit. Status bit 7 reads 1 when that bit was high (NACK) and 0 when it was low (ACK).
- R5: Command bit 5 (READ) shifts in 8 bits MSB first into the receive register. Afterwards the master drives the acknowledge bit low when command bit 3 was 0, and releases it (NACK) when command bit 3 was 1.
- R6: Command bit 6 (STOP) generates a stop condition, after the acknowledge bit when it is combined with a read or write. Status bit 6 clears when a stop condition (SDA rising while SCL is high) is seen.
- R7: Status bit 1 (transfer in progress) is high from acceptance of a command until its byte, its acknowledge bit and any requested stop have completed. Command bits clear themselves once accepted, so a command runs exactly once.
- R8: Status bit 0 (interrupt flag) sets when a command completes or arbitration is lost. Writing command bit 0 clears it. The `irq` output follows the flag only while control bit 6 is 1.
- R9: While control bit 7 is 0, command writes are discarded: no bus activity follows, then or after the core is enabled.
- R10: Arbitration is lost in two cases. One is when the master releases SDA to high while SCL is high and samples it low. The other is when a stop condition appears that the master did not request. On loss, both lines are released at once, the transfer ends, and status bits 5 and 0 set. Bit 5 clears when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write strobe, one cycle per write |
| host_rdata | output | 8 | Registered read data for the offset of the previous cycle |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Arbitration loss is the hardest case to reach from the ports, because it needs a second agent on the shared SDA wire. The bench adds its own pull-down on SDA and holds it low before issuing a START. The master then sees SDA low at a moment when it has released the line while SCL is high. The pull-down also produces an external start, and then an external stop when it is released, so the same sequence checks that busy tracking works without the master's involvement.

The read path needs a responding slave that stays in step with the bit counts. The bench model counts SCL edges after each start and serves a computed byte sequence. It also stops driving as soon as the master answers with NACK.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

  typedef enum logic [2:0] {BC_IDLE, BC_START, BC_STOP, BC_WR, BC_RD} bit_cmd_t;
  typedef enum logic [2:0] {BS_IDLE, BS_START, BS_DATA, BS_ACK, BS_STOP} byte_st_t;

  localparam logic [2:0] OFS_PRE_LO = 3'd0;
  localparam logic [2:0] OFS_PRE_HI = 3'd1;
  localparam logic [2:0] OFS_CTRL   = 3'd2;
  localparam logic [2:0] OFS_DATA   = 3'd3;
  localparam logic [2:0] OFS_CMD    = 3'd4;

  localparam int CMD_STA  = 7;
  localparam int CMD_STO  = 6;
  localparam int CMD_RD   = 5;
  localparam int CMD_WR   = 4;
  localparam int CMD_NACK = 3;
  localparam int CMD_IACK = 0;
  localparam int CTL_EN   = 7;
  localparam int CTL_IEN  = 6;

  localparam int PHASES = 5;

  // Levels {scl, sda} requested for one phase of one bit-level action.
  function automatic logic [1:0] line_levels(bit_cmd_t c, logic [2:0] ph, logic d);
    logic [1:0] r;
    r = 2'b11;
    case (c)
      BC_START: case (ph)
        3'd0:       r = 2'b01;
        3'd1, 3'd2: r = 2'b11;
        3'd3:       r = 2'b10;
        default:    r = 2'b00;
      endcase
      BC_STOP: case (ph)
        3'd0:       r = 2'b00;
        3'd1, 3'd2: r = 2'b10;
        default:    r = 2'b11;
      endcase
      BC_WR, BC_RD: r = {(ph != 3'd0) && (ph != 3'd4), d};
      default: r = 2'b11;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic stop_det,
  output logic busy
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_ff, sda_ff;
  logic scl_p, sda_p, scl_s, start_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[TOP-1:0], scl_in};
      sda_ff <= {sda_ff[TOP-1:0], sda_in};
      scl_p  <= scl_ff[TOP];
      sda_p  <= sda_ff[TOP];
    end
  end

  assign scl_s     = scl_ff[TOP];
  assign sda_s     = sda_ff[TOP];
  assign start_det = scl_p && scl_s && sda_p && !sda_s;
  assign stop_det  = scl_p && scl_s && !sda_p && sda_s;

  always_ff @(posedge clk) begin
    if (rst)            busy <= 1'b0;
    else if (start_det) busy <= 1'b1;
    else if (stop_det)  busy <= 1'b0;
  end

  assert_busy_set_R3: assert property (@(posedge clk) disable iff (rst)
    start_det |=> busy);
  assert_busy_clr_R6: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bm_pkg::*;
#(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre,
  input  logic             go,
  input  bit_cmd_t         cmd,
  input  logic             din,
  input  logic             sda_s,
  input  logic             stop_det,
  output logic             done,
  output logic             dout,
  output logic             lost,
  output logic             active,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam logic [2:0] LAST_PH = 3'(PHASES - 1);
  localparam logic [2:0] SAMP_PH = 3'd2;

  bit_cmd_t         cur;
  logic             cur_din;
  logic [2:0]       ph;
  logic [PRE_W-1:0] cnt;
  logic [1:0]       lvl;
  logic             tick, chk_high;

  assign tick     = active && (cnt == '0);
  assign chk_high = (cur == BC_START) || ((cur == BC_WR) && cur_din);
  assign lost     = active && ((tick && (ph == SAMP_PH) && chk_high && !sda_s) ||
                               (stop_det && (cur != BC_STOP)));
  assign done     = tick && (ph == LAST_PH) && !lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cur     <= BC_IDLE;
      cur_din <= 1'b1;
      ph      <= '0;
      cnt     <= '0;
      lvl     <= 2'b11;
      dout    <= 1'b1;
    end else if (lost) begin
      active <= 1'b0;
      lvl    <= 2'b11;
    end else if (go) begin
      active  <= 1'b1;
      cur     <= cmd;
      cur_din <= din;
      ph      <= '0;
      cnt     <= pre;
      lvl     <= line_levels(cmd, 3'd0, din);
    end else if (tick) begin
      cnt <= pre;
      if (ph == SAMP_PH) dout <= sda_s;
      if (ph == LAST_PH) active <= 1'b0;
      else begin
        ph  <= ph + 3'd1;
        lvl <= line_levels(cur, ph + 3'd1, cur_din);
      end
    end else if (active) begin
      cnt <= cnt - PRE_W'(1);
    end
  end

  assign scl_oe = !lvl[1];
  assign sda_oe = !lvl[0];

  assert_release_on_loss_R10: assert property (@(posedge clk) disable iff (rst)
    lost |=> (!scl_oe && !sda_oe));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int PRE_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       host_we,
  output logic [7:0] host_rdata,
  output logic       irq,
  input  logic       scl_in,
  output logic       scl_oe,
  input  logic       sda_in,
  output logic       sda_oe
);
  localparam int HI_W = PRE_W - 8;

  logic [PRE_W-1:0] pre;
  logic       en, ien;
  logic [7:0] txr, rxr, sr;
  logic       pend_sta, pend_sto, pend_rd, pend_wr, pend_nack;
  logic       op_sto, op_wr, op_nack;
  byte_st_t   st;
  logic [2:0] bitcnt;
  logic       rxack, al, iflag;

  logic       sda_s, stop_det, busy;
  logic       done, dout, lost, eng_act;
  logic       go, bdin, accept, finish, wr_cmd, tip;
  bit_cmd_t   bcmd;
  logic [7:0] status;

  i2c_line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .stop_det(stop_det), .busy(busy));

  i2c_bit_engine #(.PRE_W(PRE_W)) u_bits (
    .clk(clk), .rst(rst), .pre(pre), .go(go), .cmd(bcmd), .din(bdin),
    .sda_s(sda_s), .stop_det(stop_det), .done(done), .dout(dout),
    .lost(lost), .active(eng_act), .scl_oe(scl_oe), .sda_oe(sda_oe));

  assign wr_cmd = host_we && (host_addr == OFS_CMD);
  assign accept = (st == BS_IDLE) && (pend_sta || pend_sto || pend_rd || pend_wr);
  assign finish = done && (((st == BS_ACK) && !op_sto) || (st == BS_STOP));
  assign tip    = (st != BS_IDLE);

  // Next bit-level action, issued in the same cycle the previous one ends.
  always_comb begin
    go   = 1'b0;
    bcmd = BC_IDLE;
    bdin = 1'b1;
    case (st)
      BS_IDLE: if (accept) begin
        go = 1'b1;
        if (pend_sta)     bcmd = BC_START;
        else if (pend_wr) begin bcmd = BC_WR; bdin = txr[7]; end
        else if (pend_rd) bcmd = BC_RD;
        else              bcmd = BC_STOP;
      end
      BS_START: if (done) begin
        go = 1'b1; bcmd = BC_WR; bdin = sr[7];
      end
      BS_DATA: if (done) begin
        go = 1'b1;
        if (bitcnt != 3'd0) begin
          bcmd = op_wr ? BC_WR : BC_RD;
          bdin = op_wr ? sr[6] : 1'b1;
        end else begin
          bcmd = op_wr ? BC_RD : BC_WR;
          bdin = op_wr ? 1'b1 : op_nack;
        end
      end
      BS_ACK: if (done && op_sto) begin
        go = 1'b1; bcmd = BC_STOP;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '1; en <= 1'b0; ien <= 1'b0;
      txr <= '0; rxr <= '0; sr <= '0;
      {pend_sta, pend_sto, pend_rd, pend_wr, pend_nack} <= '0;
      {op_sto, op_wr, op_nack} <= '0;
      st <= BS_IDLE; bitcnt <= '0;
      rxack <= 1'b0; al <= 1'b0; iflag <= 1'b0; irq <= 1'b0;
    end else begin
      if (host_we) begin
        case (host_addr)
          OFS_PRE_LO: pre[7:0] <= host_wdata;
          OFS_PRE_HI: pre[PRE_W-1:8] <= host_wdata[HI_W-1:0];
          OFS_CTRL:   begin en <= host_wdata[CTL_EN]; ien <= host_wdata[CTL_IEN]; end
          OFS_DATA:   txr <= host_wdata;
          default: ;
        endcase
      end
      if (accept) {pend_sta, pend_sto, pend_rd, pend_wr, pend_nack} <= '0;
      if (wr_cmd && en) begin
        pend_sta  <= host_wdata[CMD_STA];
        pend_sto  <= host_wdata[CMD_STO];
        pend_rd   <= host_wdata[CMD_RD];
        pend_wr   <= host_wdata[CMD_WR];
        pend_nack <= host_wdata[CMD_NACK];
      end
      if (lost || finish)                   iflag <= 1'b1;
      else if (wr_cmd && host_wdata[CMD_IACK]) iflag <= 1'b0;
      if (lost)        al <= 1'b1;
      else if (accept) al <= 1'b0;
      irq <= iflag && ien;

      if (lost) st <= BS_IDLE;
      else begin
        case (st)
          BS_IDLE: if (accept) begin
            op_sto  <= pend_sto;
            op_wr   <= pend_sta || pend_wr;
            op_nack <= pend_nack;
            sr      <= txr;
            bitcnt  <= 3'd7;
            st      <= pend_sta ? BS_START : ((pend_rd || pend_wr) ? BS_DATA : BS_STOP);
          end
          BS_START: if (done) begin st <= BS_DATA; bitcnt <= 3'd7; end
          BS_DATA: if (done) begin
            sr <= {sr[6:0], dout};
            if (bitcnt == 3'd0) st <= BS_ACK;
            else bitcnt <= bitcnt - 3'd1;
          end
          BS_ACK: if (done) begin
            if (op_wr) rxack <= dout;
            else       rxr   <= sr;
            st <= op_sto ? BS_STOP : BS_IDLE;
          end
          BS_STOP: if (done) st <= BS_IDLE;
          default: st <= BS_IDLE;
        endcase
      end
    end
  end

  assign status = {rxack, busy, al, 3'b000, tip, iflag};

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else begin
      case (host_addr)
        OFS_PRE_LO: host_rdata <= pre[7:0];
        OFS_PRE_HI: host_rdata <= 8'(pre >> 8);
        OFS_CTRL:   host_rdata <= {en, ien, 6'b000000};
        OFS_DATA:   host_rdata <= rxr;
        OFS_CMD:    host_rdata <= status;
        default:    host_rdata <= '0;
      endcase
    end
  end

  assert_iack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && host_wdata[CMD_IACK] && !lost && !finish) |=> !iflag);
  assert_cmd_selfclear_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && !host_we) |=> !(pend_sta || pend_sto || pend_rd || pend_wr));
  assert_tip_covers_bus_R7: assert property (@(posedge clk) disable iff (rst)
    eng_act |-> tip);

endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_we = 1'b0;
  logic [7:0] host_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       scl_w, sda_w;

  logic       slv_low = 1'b0, rogue_low = 1'b0, ack_en = 1'b1;
  logic       sl_act = 1'b0, first = 1'b0, rdmode = 1'b0, ms_ack = 1'b0;
  logic [7:0] sh = '0, got = '0, cur_rd = '0;
  int bitn = 0, rd_idx = 0, stops = 0;
  int cyc = 0, last_rise = 0, period = 0, scl_rises = 0;
  int nchk = 0, nerr = 0;
  logic [7:0] s;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_w = !scl_oe;
  assign sda_w = !sda_oe && !slv_low && !rogue_low;

  i2c_byte_master u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rdata(host_rdata), .irq(irq),
    .scl_in(scl_w), .scl_oe(scl_oe), .sda_in(sda_w), .sda_oe(sda_oe));

  function automatic logic [7:0] rdpat(int k);
    return 8'((k * 53 + 60) & 255);
  endfunction

  // Slave model.
  always @(posedge scl_w) begin
    period = cyc - last_rise;
    last_rise = cyc;
    scl_rises++;
    if (sl_act) begin
      if (bitn >= 0 && bitn < 8) sh = {sh[6:0], sda_w};
      else if (bitn == 8) ms_ack = sda_w;
    end
  end
  always @(negedge sda_w) if (scl_w) begin
    sl_act = 1'b1; bitn = -1; first = 1'b1; rdmode = 1'b0; slv_low = 1'b0;
  end
  always @(posedge sda_w) if (scl_w) begin
    sl_act = 1'b0; slv_low = 1'b0; stops++;
  end
  always @(negedge scl_w) if (sl_act) begin
    bitn = bitn + 1;
    if (bitn == 8) begin
      if (first || !rdmode) begin
        got = sh;
        if (first) rdmode = sh[0];
        slv_low = ack_en;
      end else slv_low = 1'b0;
    end else if (bitn == 9) begin
      bitn = 0; slv_low = 1'b0;
      if (first) first = 1'b0;
      else if (rdmode && ms_ack) rdmode = 1'b0;
      if (rdmode) begin
        cur_rd = rdpat(rd_idx); rd_idx++;
        slv_low = !cur_rd[7];
      end
    end else if (rdmode && !first && bitn > 0) slv_low = !cur_rd[7-bitn];
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      hrd(3'd4, v);
      if (!v[1]) return;
    end
    chk("R7 transfer never finished", 1, 0);
  endtask

  task automatic xfer(input logic [7:0] c);
    logic [7:0] v;
    hwr(3'd4, c);
    repeat (3) @(negedge clk);
    hrd(3'd4, v);
    chk("R7 tip after command", int'(v[1]), 1);
    wait_idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    int r;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hrd(3'd4, s); chk("R1 status reset", s, 8'h00);
    hrd(3'd0, s); chk("R1 prescale low reset", s, 8'hFF);
    hrd(3'd1, s); chk("R1 prescale high reset", s, 8'hFF);
    hrd(3'd2, s); chk("R1 control reset", s, 8'h00);
    hwr(3'd0, 8'd3); hwr(3'd1, 8'd0);
    hrd(3'd0, s); chk("R1 prescale low readback", s, 8'd3);
    hrd(3'd1, s); chk("R1 prescale high readback", s, 8'd0);

    // R9: core disabled
    r = scl_rises;
    hwr(3'd3, 8'hA0); hwr(3'd4, 8'h91);
    repeat (100) @(negedge clk);
    hrd(3'd4, s); chk("R9 no tip while disabled", int'(s[1]), 0);
    hwr(3'd2, 8'hC0);
    repeat (200) @(negedge clk);
    chk("R9 no SCL activity after enable", scl_rises, r);
    hrd(3'd2, s); chk("R1 control readback", s, 8'hC0);

    // R3: start + address
    xfer(8'h91);
    chk("R3 address byte on bus", got, 8'hA0);
    hrd(3'd4, s);
    chk("R3 busy after start", int'(s[6]), 1);
    chk("R4 address ACK", int'(s[7]), 0);
    chk("R8 flag after byte", int'(s[0]), 1);
    chk("R8 irq enabled", int'(irq), 1);
    chk("R2 bit period P=3", period, 20);

    // R4: write sweep
    for (int k = 0; k < 12; k++) begin
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 73 + 17) & 255);
      hwr(3'd3, v); xfer(8'h11);
      chk("R4 written byte", got, v);
      hrd(3'd4, s); chk("R4 ACK seen", int'(s[7]), 0);
    end

    // R7: command ran once
    r = scl_rises;
    repeat (300) @(negedge clk);
    chk("R7 no repeat of command", scl_rises, r);

    // R8: acknowledge clears flag and irq
    hwr(3'd4, 8'h01);
    hrd(3'd4, s); chk("R8 flag cleared by IACK", int'(s[0]), 0);
    @(negedge clk); chk("R8 irq cleared", int'(irq), 0);

    // R4: NACK from slave
    ack_en = 1'b0;
    hwr(3'd3, 8'h3C); xfer(8'h11);
    hrd(3'd4, s); chk("R4 NACK reported", int'(s[7]), 1);
    ack_en = 1'b1;

    // R6: stop
    r = stops;
    xfer(8'h41);
    hrd(3'd4, s); chk("R6 busy cleared after stop", int'(s[6]), 0);
    chk("R6 stop condition on bus", stops, r + 1);

    // R5: reads
    hwr(3'd3, 8'hA1); xfer(8'h91);
    chk("R3 read address", got, 8'hA1);
    for (int k = 0; k < 6; k++) begin
      xfer((k == 5) ? 8'h69 : 8'h21);
      hrd(3'd3, s); chk("R5 received byte", s, rdpat(k));
      chk("R5 master ack level", int'(ms_ack), (k == 5) ? 1 : 0);
    end
    hrd(3'd4, s); chk("R6 busy clear after read+stop", int'(s[6]), 0);

    // R8: masked interrupt
    hwr(3'd2, 8'h80); hwr(3'd4, 8'h01);
    hwr(3'd3, 8'hA0); xfer(8'h91);
    hrd(3'd4, s); chk("R8 flag set when masked", int'(s[0]), 1);
    @(negedge clk); chk("R8 irq masked", int'(irq), 0);
    xfer(8'h41);

    // R2: divider sweep
    for (int p = 1; p <= 7; p += 3) begin
      hwr(3'd0, 8'(p));
      hwr(3'd3, 8'hA0); xfer(8'h91);
      chk("R2 bit period", period, 5 * (p + 1));
      xfer(8'h41);
    end
    hwr(3'd0, 8'd3); hwr(3'd2, 8'hC0);

    // R10: arbitration loss
    rogue_low = 1'b1;
    repeat (20) @(negedge clk);
    hwr(3'd3, 8'hA0); hwr(3'd4, 8'h91);
    repeat (3) @(negedge clk);
    wait_idle();
    hrd(3'd4, s);
    chk("R10 arbitration lost bit", int'(s[5]), 1);
    chk("R10 flag on loss", int'(s[0]), 1);
    chk("R10 SCL released", int'(scl_oe), 0);
    chk("R10 SDA released", int'(sda_oe), 0);
    rogue_low = 1'b0;
    repeat (10) @(negedge clk);
    hrd(3'd4, s); chk("R6 external stop clears busy", int'(s[6]), 0);
    hwr(3'd3, 8'hA0); xfer(8'h91);
    hrd(3'd4, s); chk("R10 loss bit cleared by next command", int'(s[5]), 0);
    chk("R10 bus usable after loss", got, 8'hA0);
    xfer(8'h41);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule